// File: doc/BRIEF.md
# Serial Scan Register Access Port

This block is the data path behind a serial test port that lets an external debugger read and write a bank of 32-bit registers. The port's state machine sits outside the block and shows up here only as capture, shift and update strobes, one set for the instruction path and one for the data path. A 4-bit instruction register chooses which data path sits between the serial input and the serial output. One instruction opens a 5-bit chain-number register. Another instruction opens the 40-bit register access chain, but only when chain 0 is the selected chain number. Every other case uses a 1-bit bypass stage.

Each scan of the access chain carries a data field, a register address and a direction flag. When the scan's update strobe arrives, the block drives a one-cycle write strobe or read strobe toward the register bank. Reads are pipelined. The word returned by the bank is held inside the block and is shifted out in the data field of the next access scan. A debugger therefore finishes a run of reads with a scan aimed at a register that has no side effects when read, such as address 0, so that no data read is issued twice.

Top module: `scan_reg_port`

## Requirements
- R1: After reset the instruction is the bypass code 0xF, the chain number is 0, both strobes are low and the held read word is 0. A data scan of n bits therefore returns a 0 first and then the input bits delayed by one position.
- R2: The instruction register is 4 bits wide and shifts least significant bit first. Its capture loads 4'b0001. Its update makes the shifted-in code the current instruction.
- R3: Code 0x2 places the 5-bit chain-number register on the data path. Capture loads the current chain number, which shifts out LSB first. Update loads the shifted-in value.
- R4: Code 0xC with chain number 0 places the 40-bit access chain on the data path. Shift order is data bits 0..31, then address bits 0..6 (chain bits 32..38), then the direction flag (chain bit 39). Capture loads the held read word into bits 31:0 and zero into bits 39:32.
- R5: An update of the access chain with flag 1 raises reg_we_o for exactly one cycle, in the cycle after the update strobe. The shifted address and data are on reg_addr_o and reg_wdata_o during that cycle. The address output changes only after an update.
- R6: An update with flag 0 raises reg_re_o for exactly one cycle, in the cycle after the update strobe. reg_rdata_i is latched in that cycle and appears in the data field of the next access scan, not the one that issued the read.
- R7: The held read word changes only on a read. Scans that write leave it unchanged.
- R8: Any instruction code other than 0x2 and 0xC, and code 0xC with a nonzero chain number, selects a 1-bit bypass stage that captures 0. An update in these cases raises no strobe and changes no register.
- R9: reg_we_o and reg_re_o are never high together, and each access scan produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (LSB of the active path) |
| ir_capture_i | input | 1 | Instruction path capture strobe |
| ir_shift_i | input | 1 | Instruction path shift enable |
| ir_update_i | input | 1 | Instruction path update strobe |
| dr_capture_i | input | 1 | Data path capture strobe |
| dr_shift_i | input | 1 | Data path shift enable |
| dr_update_i | input | 1 | Data path update strobe |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_addr_o | output | 7 | Register address |
| reg_wdata_o | output | 32 | Register write data |
| reg_rdata_i | input | 32 | Register read data, valid while reg_re_o is high |

## Verification
The bench targets the one-scan read latency. A design that returns the read word in the same scan, or that reloads the held word on a write scan, shifts out the wrong word on the scans that follow a read. It also exercises chain selection: it moves the chain number away from 0 and then issues a write with code 0xC. A design that ignores the chain number would write the bank at that point. Unknown instruction codes and the bypass timing right after reset are checked as well, because an off-by-one in the bypass stage or an incorrect capture value shows up in the first bit shifted out.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;
  localparam int IR_W   = 4;
  localparam int SEL_W  = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 7;
  localparam int CHAIN_W = DATA_W + ADDR_W + 1;

  localparam logic [IR_W-1:0] INS_CHAIN_SEL = 4'h2;
  localparam logic [IR_W-1:0] INS_REG_ACC   = 4'hC;
  localparam logic [IR_W-1:0] INS_BYPASS    = 4'hF;
  localparam logic [IR_W-1:0] IR_CAP_VAL    = 4'b0001;
  localparam logic [SEL_W-1:0] ACC_CHAIN    = '0;

  typedef enum logic [1:0] {
    PATH_BYPASS = 2'd0,
    PATH_SEL    = 2'd1,
    PATH_ACC    = 2'd2
  } dr_path_e;
endpackage

// File: rtl/scan_shift_reg.sv
module scan_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         shift_i,
  input  logic [W-1:0] cap_val_i,
  input  logic         tdi_i,
  output logic [W-1:0] sr_o
);
  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_o <= '0;
        else if (cap_i)   sr_o <= cap_val_i;
        else if (shift_i) sr_o <= tdi_i;
      end
    end else begin : g_multi
      // tdi enters at the MSB, LSB leaves first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sr_o <= '0;
        else if (cap_i)   sr_o <= cap_val_i;
        else if (shift_i) sr_o <= {tdi_i, sr_o[W-1:1]};
      end
    end
  endgenerate
endmodule

// File: rtl/scan_access_ctrl.sv
module scan_access_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              we_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      re_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= upd_i & wr_i;
      re_o <= upd_i & ~wr_i;
      if (upd_i) begin
        addr_o  <= addr_i;
        wdata_o <= data_i;
      end
    end
  end

  // read result is kept for the next scan's capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_o <= '0;
    else if (re_o) hold_o <= rdata_i;
  end
endmodule

// File: rtl/scan_reg_port.sv
module scan_reg_port
  import scan_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic              ir_capture_i,
  input  logic              ir_shift_i,
  input  logic              ir_update_i,
  input  logic              dr_capture_i,
  input  logic              dr_shift_i,
  input  logic              dr_update_i,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [IR_W-1:0]    ir_sr, ir_q;
  logic [SEL_W-1:0]   sel_sr, sel_q;
  logic [CHAIN_W-1:0] acc_sr;
  logic [0:0]         byp_sr;
  logic [DATA_W-1:0]  hold;
  dr_path_e           path;

  always_comb begin
    unique case (ir_q)
      INS_CHAIN_SEL: path = PATH_SEL;
      INS_REG_ACC:   path = (sel_q == ACC_CHAIN) ? PATH_ACC : PATH_BYPASS;
      default:       path = PATH_BYPASS;
    endcase
  end

  logic sel_en, acc_en, byp_en;
  assign sel_en = (path == PATH_SEL);
  assign acc_en = (path == PATH_ACC);
  assign byp_en = (path == PATH_BYPASS);

  scan_shift_reg #(.W(IR_W)) u_ir (
    .clk_i, .rst_ni,
    .cap_i(ir_capture_i), .shift_i(ir_shift_i),
    .cap_val_i(IR_CAP_VAL), .tdi_i, .sr_o(ir_sr)
  );

  scan_shift_reg #(.W(SEL_W)) u_sel (
    .clk_i, .rst_ni,
    .cap_i(dr_capture_i & sel_en), .shift_i(dr_shift_i & sel_en),
    .cap_val_i(sel_q), .tdi_i, .sr_o(sel_sr)
  );

  scan_shift_reg #(.W(CHAIN_W)) u_acc (
    .clk_i, .rst_ni,
    .cap_i(dr_capture_i & acc_en), .shift_i(dr_shift_i & acc_en),
    .cap_val_i({{(CHAIN_W-DATA_W){1'b0}}, hold}), .tdi_i, .sr_o(acc_sr)
  );

  scan_shift_reg #(.W(1)) u_byp (
    .clk_i, .rst_ni,
    .cap_i(dr_capture_i & byp_en), .shift_i(dr_shift_i & byp_en),
    .cap_val_i(1'b0), .tdi_i, .sr_o(byp_sr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ir_q <= INS_BYPASS;
    else if (ir_update_i) ir_q <= ir_sr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   sel_q <= ACC_CHAIN;
    else if (dr_update_i & sel_en) sel_q <= sel_sr;
  end

  scan_access_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .upd_i   (dr_update_i & acc_en),
    .wr_i    (acc_sr[CHAIN_W-1]),
    .addr_i  (acc_sr[DATA_W +: ADDR_W]),
    .data_i  (acc_sr[DATA_W-1:0]),
    .rdata_i (reg_rdata_i),
    .we_o    (reg_we_o),
    .re_o    (reg_re_o),
    .addr_o  (reg_addr_o),
    .wdata_o (reg_wdata_o),
    .hold_o  (hold)
  );

  always_comb begin
    if (ir_shift_i) tdo_o = ir_sr[0];
    else begin
      unique case (path)
        PATH_SEL: tdo_o = sel_sr[0];
        PATH_ACC: tdo_o = acc_sr[0];
        default:  tdo_o = byp_sr[0];
      endcase
    end
  end
endmodule

// File: rtl/scan_reg_port_chk.sv
module scan_reg_port_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dr_update_i,
  input logic              reg_we_o,
  input logic              reg_re_o,
  input logic [ADDR_W-1:0] reg_addr_o
);
  a_r5_we_follows_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_we_o) |-> $past(dr_update_i));

  a_r6_re_follows_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_re_o) |-> $past(dr_update_i));

  a_r9_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o}));

  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) && !dr_update_i |=> !(reg_we_o || reg_re_o));

  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dr_update_i |=> $stable(reg_addr_o));
endmodule

bind scan_reg_port scan_reg_port_chk #(.ADDR_W(scan_port_pkg::ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dr_update_i(dr_update_i),
  .reg_we_o(reg_we_o), .reg_re_o(reg_re_o), .reg_addr_o(reg_addr_o)
);

// File: tb/scan_reg_port_test.sv
`timescale 1ns/1ps
module scan_reg_port_test;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic tdi = 1'b0, tdo;
  logic ir_cap = 1'b0, ir_sh = 1'b0, ir_up = 1'b0;
  logic dr_cap = 1'b0, dr_sh = 1'b0, dr_up = 1'b0;
  logic we, re;
  logic [6:0]  addr;
  logic [31:0] wdata, rdata;
  logic [31:0] bank [16];

  int tests = 0, fails = 0, we_cnt = 0, re_cnt = 0;

  typedef struct { string tag; logic [39:0] v; } item_t;
  item_t exp_q[$];
  logic [39:0] act_q[$];

  always #2.5 clk = ~clk;

  scan_reg_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .tdi_i(tdi), .tdo_o(tdo),
    .ir_capture_i(ir_cap), .ir_shift_i(ir_sh), .ir_update_i(ir_up),
    .dr_capture_i(dr_cap), .dr_shift_i(dr_sh), .dr_update_i(dr_up),
    .reg_we_o(we), .reg_re_o(re), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  // register bank model
  assign rdata = bank[addr[3:0]];
  always @(posedge clk) begin
    if (we) bank[addr[3:0]] <= wdata;
    if (we) we_cnt++;
    if (re) re_cnt++;
  end

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t e;
      logic [39:0] a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      chk(e.tag, a, e.v);
    end
  end

  task automatic ir_scan(input string tag, input logic [3:0] code);
    logic [39:0] d = '0;
    exp_q.push_back('{tag, 40'h1});
    @(negedge clk) ir_cap = 1'b1;
    @(negedge clk) ir_cap = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ir_sh = 1'b1; tdi = code[i]; #1 d[i] = tdo;
      @(negedge clk);
    end
    ir_sh = 1'b0; ir_up = 1'b1;
    @(negedge clk) ir_up = 1'b0;
    act_q.push_back(d);
  endtask

  task automatic dr_scan(input string tag, input int n, input logic [39:0] din,
                         input logic [39:0] exp);
    logic [39:0] d = '0;
    exp_q.push_back('{tag, exp});
    @(negedge clk) dr_cap = 1'b1;
    @(negedge clk) dr_cap = 1'b0;
    for (int i = 0; i < n; i++) begin
      dr_sh = 1'b1; tdi = din[i]; #1 d[i] = tdo;
      @(negedge clk);
    end
    dr_sh = 1'b0; dr_up = 1'b1;
    @(negedge clk) dr_up = 1'b0;
    @(negedge clk);
    @(negedge clk);
    act_q.push_back(d);
  endtask

  function automatic logic [39:0] acc(input logic wr, input logic [6:0] a, input logic [31:0] d);
    return {wr, a, d};
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #200000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) bank[i] = 32'h1000_0000 + i;
    bank[0] = 32'h1234_5678;
    #12 rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 strobes idle", {38'd0, we, re}, 40'd0);
    // R1: reset bypass, first bit 0 then delayed input
    dr_scan("R1 bypass after reset", 8, 40'hA5, {32'd0, 8'h4A});
    chk("R1 no strobe in bypass", 40'(we_cnt + re_cnt), 40'd0);

    // R2/R3: chain select
    ir_scan("R2 ir capture", 4'h2);
    dr_scan("R3 sel capture initial", 5, 40'd3, 40'd0);
    dr_scan("R3 sel capture updated", 5, 40'd0, 40'd3);

    // R4/R5: write under access chain
    ir_scan("R2 ir capture again", 4'hC);
    dr_scan("R4 first capture holds zero", 40, acc(1'b1, 7'd5, 32'hDEAD_BEEF), 40'd0);
    chk("R5 write landed", {8'd0, bank[5]}, {8'd0, 32'hDEAD_BEEF});
    chk("R5 write addr", {33'd0, addr}, 40'd5);
    chk("R9 one write strobe", 40'(we_cnt), 40'd1);

    // R6: read latency of one scan
    dr_scan("R6 read issue scan", 40, acc(1'b0, 7'd5, 32'hFFFF_FFFF), 40'd0);
    chk("R9 one read strobe", 40'(re_cnt), 40'd1);
    dr_scan("R6 read returns next scan", 40, acc(1'b0, 7'd0, 32'd0), {8'd0, 32'hDEAD_BEEF});
    dr_scan("R6 harmless read returned", 40, acc(1'b1, 7'd9, 32'hCAFE_F00D), {8'd0, 32'h1234_5678});
    // R7: write scans leave held word alone
    dr_scan("R7 hold kept over write", 40, acc(1'b1, 7'd10, 32'h0BAD_CAFE), {8'd0, 32'h1234_5678});
    chk("R5 second writes", {8'd0, bank[9]}, {8'd0, 32'hCAFE_F00D});
    chk("R9 strobe counts", {8'(we_cnt), 8'(re_cnt)}, {8'd3, 8'd2});

    // R8: unknown code gives bypass, no strobe
    ir_scan("R2 ir capture unknown", 4'h7);
    dr_scan("R8 unknown code bypass", 40, acc(1'b1, 7'd11, 32'h5555_AAAA),
            acc(1'b1, 7'd11, 32'h5555_AAAA) << 1);
    chk("R8 unknown no write", {8'd0, bank[11]}, {8'd0, 32'h1000_000B});

    // R8: access code with nonzero chain number gives bypass
    ir_scan("R2 ir capture sel", 4'h2);
    dr_scan("R3 sel capture zero", 5, 40'd1, 40'd0);
    ir_scan("R2 ir capture acc", 4'hC);
    dr_scan("R8 nonzero chain bypass", 40, acc(1'b1, 7'd11, 32'h7777_0000),
            acc(1'b1, 7'd11, 32'h7777_0000) << 1);
    chk("R8 nonzero chain no write", {8'd0, bank[11]}, {8'd0, 32'h1000_000B});
    chk("R8 strobe counts unchanged", {8'(we_cnt), 8'(re_cnt)}, {8'd3, 8'd2});

    repeat (4) @(negedge clk);
    chk("scoreboard drained", 40'(exp_q.size() + act_q.size()), 40'd0);
    finish_run();
  end
endmodule